// File: doc/BRIEF.md
# CD Subcode User-Channel Framer

This block takes the user-channel bit stream that an upstream digital-audio receiver recovers, one bit per audio frame, offered on a valid/ready input. Every accepted bit is packed into a 32-bit user word. The first bit of each group of 32 lands in bit 31.

When subcode mode is on, the block also parses the stream into subcode symbols and finds the subcode frame boundaries. A data symbol is a 1 start bit followed by seven payload bits. A zero symbol is a run of eleven 0 bits. The block pulls the Q bit out of every data symbol into a second 32-bit word, and it checks that each subcode frame has the right length. Any framing fault sets a sticky flag that stays high until software clears it.

The input never applies back-pressure. `in_ready` goes high on the first clock edge after reset and stays high. A bit is consumed on every edge where `in_valid` and `in_ready` are both high. Holding `in_valid` low only pauses the stream, and no parser state is lost while it is low.

Top module: `cdsub_sync_rx`

## Requirements
- R1: Each accepted bit shifts into the user word so that the first of every 32 bits ends up in bit 31. `user_word` updates, and `user_word_vld` pulses for one cycle, on the edge that accepts the 32nd bit. Between updates `user_word` holds its value. This happens in both modes.
- R2: `in_ready` is 0 during reset and 1 from the first edge after reset onward. The block never stalls the input.
- R3: In subcode mode, outside a data symbol, a 1 bit opens a data symbol. The start bit is followed by seven payload bits, and the first payload bit is the Q bit. Eleven consecutive 0 bits seen outside a data symbol form a zero symbol.
- R4: When four successive symbols are data, zero, zero, data, a frame sync occurs on the last data symbol. `frame_sync` pulses one cycle after the edge that accepts that symbol's final bit.
- R5: After a first sync has been found, a sync is assumed on the 98th symbol after the previous sync even if the pattern is absent. This assumed sync also pulses `frame_sync`.
- R6: `len_err` is set when a pattern sync arrives at a distance other than 98 symbols from the previous sync. It is also set when an assumed sync of R5 fires. The first sync after mode entry never sets it.
- R7: `len_err` is set at a pattern sync when the number of Q bits collected since the previous sync is not 96. The count includes the Q bit of the previous sync symbol itself.
- R8: Q bits are packed MSB-first into `q_word`, and `q_word_vld` pulses when the 32nd bit arrives. Every sync restarts packing, and the Q bit of the symbol that carries the sync becomes bit 31 of the next word.
- R9: With `sync_en` low, no symbols are parsed and no frame syncs, Q words or length errors are produced. User words are still collected.
- R10: `len_err` is sticky and is cleared by a one-cycle `err_clr`. If a new error and `err_clr` fall on the same edge, the flag stays set.
- R11: After reset, `user_word_vld`, `q_word_vld`, `frame_sync` and `len_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_en | input | 1 | Subcode mode: enables symbol parsing, sync and Q capture |
| err_clr | input | 1 | Clears the sticky length-error flag |
| in_valid | input | 1 | User bit offered |
| in_ready | output | 1 | Block accepts a bit (always high after reset) |
| in_bit | input | 1 | User-channel bit |
| user_word | output | 32 | Last complete user word, first bit in bit 31 |
| user_word_vld | output | 1 | One-cycle pulse when `user_word` updates |
| q_word | output | 32 | Last complete Q word, first bit in bit 31 |
| q_word_vld | output | 1 | One-cycle pulse when `q_word` updates |
| frame_sync | output | 1 | One-cycle pulse on each pattern or assumed sync |
| len_err | output | 1 | Sticky frame-length / Q-count error |

## Verification
Two functions can act on the same edge: a framing fault that raises `len_err`, and a software clear of that same flag. The bench provokes the overlap by holding `err_clr` high during the final bit of a data symbol that closes an early sync pattern. It then requires the flag to still read 1 afterwards. A separate plain clear, with no fault on that edge, must bring the flag to 0.

// File: rtl/cdsub_pkg.sv
package cdsub_pkg;
  localparam int WORD_W_DEF  = 32;
  localparam int FRAME_DEF   = 98;
  localparam int PAYLOAD_DEF = 7;
  localparam int ZRUN_DEF    = 11;

  typedef enum logic [1:0] {
    SYM_NONE = 2'd0,
    SYM_DATA = 2'd1,
    SYM_ZERO = 2'd2
  } sym_kind_e;
endpackage

// File: rtl/cdsub_bit_packer.sv
module cdsub_bit_packer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         restart,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         word_vld
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh;
  logic [CW-1:0] fill;
  logic [W-1:0]  nxt;

  assign nxt = {sh[W-2:0], din};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      fill     <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (restart) begin
        fill <= push ? CW'(1) : '0;
        if (push) sh <= {{(W-1){1'b0}}, din};
      end else if (push) begin
        sh <= nxt;
        if (fill == CW'(W-1)) begin
          word     <= nxt;
          word_vld <= 1'b1;
          fill     <= '0;
        end else begin
          fill <= fill + 1'b1;
        end
      end
    end
  end

  // R1
  word_needs_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(push));
  // R1
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word));
endmodule

// File: rtl/cdsub_sym_parser.sv
module cdsub_sym_parser
  import cdsub_pkg::*;
#(
  parameter int PAYLOAD = 7,
  parameter int ZRUN    = 11
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      bit_v,
  input  logic      bit_d,
  output sym_kind_e sym,
  output logic      sym_q
);
  localparam int PW = $clog2(PAYLOAD + 1);
  localparam int ZW = $clog2(ZRUN);

  logic [PW-1:0] pos;
  logic [ZW-1:0] zc;
  logic          q_hold;

  always_comb begin
    sym = SYM_NONE;
    if (en && bit_v) begin
      if (pos == PW'(PAYLOAD))                           sym = SYM_DATA;
      else if (pos == '0 && !bit_d && zc == ZW'(ZRUN-1)) sym = SYM_ZERO;
    end
  end

  assign sym_q = (pos == PW'(1)) ? bit_d : q_hold;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      pos    <= '0;
      zc     <= '0;
      q_hold <= 1'b0;
    end else if (bit_v) begin
      if (pos != '0) begin
        if (pos == PW'(1)) q_hold <= bit_d;
        pos <= (pos == PW'(PAYLOAD)) ? '0 : pos + 1'b1;
        zc  <= '0;
      end else if (bit_d) begin
        pos <= PW'(1);
        zc  <= '0;
      end else begin
        zc <= (zc == ZW'(ZRUN-1)) ? '0 : zc + 1'b1;
      end
    end
  end

  // R3
  parse_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pos == '0 && zc == '0));
endmodule

// File: rtl/cdsub_sync_track.sv
module cdsub_sync_track
  import cdsub_pkg::*;
#(
  parameter int FRAME = 98
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  sym_kind_e sym,
  input  logic      err_clr,
  output logic      sync_ev,
  output logic      frame_sync,
  output logic      len_err
);
  localparam int CNTW   = $clog2(FRAME + 2);
  localparam int DATA_N = FRAME - 2;

  logic [CNTW-1:0] cnt, dcnt, cnt_n;
  logic [2:0]      hist;
  logic            have, done, is_d, pat, fly, bad;

  always_comb begin
    done    = (sym != SYM_NONE);
    is_d    = (sym == SYM_DATA);
    cnt_n   = cnt + 1'b1;
    pat     = is_d && (hist == 3'b100);
    fly     = have && done && !pat && (cnt_n == CNTW'(FRAME));
    sync_ev = pat || fly;
    bad     = have && ((pat && (cnt_n != CNTW'(FRAME) || dcnt != CNTW'(DATA_N))) || fly);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt        <= '0;
      dcnt       <= '0;
      hist       <= '0;
      have       <= 1'b0;
      frame_sync <= 1'b0;
    end else begin
      frame_sync <= sync_ev;
      if (done) begin
        hist <= {hist[1:0], is_d};
        if (sync_ev) begin
          cnt  <= '0;
          dcnt <= is_d ? CNTW'(1) : '0;
          have <= 1'b1;
        end else begin
          if (cnt != CNTW'(FRAME)) cnt <= cnt_n;
          if (is_d && dcnt != CNTW'(FRAME)) dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       len_err <= 1'b0;
    else if (bad)     len_err <= 1'b1;
    else if (err_clr) len_err <= 1'b0;
  end

  // R6
  err_with_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(len_err) |-> frame_sync);
  // R10
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (!len_err || frame_sync));
  // R5
  sym_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(FRAME));
endmodule

// File: rtl/cdsub_sync_rx.sv
module cdsub_sync_rx
  import cdsub_pkg::*;
#(
  parameter int WORD_W  = WORD_W_DEF,
  parameter int FRAME   = FRAME_DEF,
  parameter int PAYLOAD = PAYLOAD_DEF,
  parameter int ZRUN    = ZRUN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_en,
  input  logic              err_clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  output logic [WORD_W-1:0] user_word,
  output logic              user_word_vld,
  output logic [WORD_W-1:0] q_word,
  output logic              q_word_vld,
  output logic              frame_sync,
  output logic              len_err
);
  logic      take, sym_q, sync_ev;
  sym_kind_e sym;

  always_ff @(posedge clk) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign take = in_valid && in_ready;

  cdsub_bit_packer #(.W(WORD_W)) u_user (
    .clk(clk), .rst_n(rst_n), .push(take), .restart(1'b0), .din(in_bit),
    .word(user_word), .word_vld(user_word_vld));

  cdsub_sym_parser #(.PAYLOAD(PAYLOAD), .ZRUN(ZRUN)) u_parse (
    .clk(clk), .rst_n(rst_n), .en(sync_en), .bit_v(take), .bit_d(in_bit),
    .sym(sym), .sym_q(sym_q));

  cdsub_sync_track #(.FRAME(FRAME)) u_track (
    .clk(clk), .rst_n(rst_n), .en(sync_en), .sym(sym), .err_clr(err_clr),
    .sync_ev(sync_ev), .frame_sync(frame_sync), .len_err(len_err));

  cdsub_bit_packer #(.W(WORD_W)) u_q (
    .clk(clk), .rst_n(rst_n), .push(sym == SYM_DATA), .restart(sync_ev), .din(sym_q),
    .word(q_word), .word_vld(q_word_vld));

  // R8
  q_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_word_vld |-> $past(sync_en));
  // R9
  sync_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> (!frame_sync && !q_word_vld));
endmodule

// File: tb/cdsub_sync_rx_test.sv
module cdsub_sync_rx_test;
  logic clk = 1'b0, rst_n = 1'b0, sync_en = 1'b0, err_clr = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, user_word_vld, q_word_vld, frame_sync, len_err;
  logic [31:0] user_word, q_word;

  int checks = 0, errors = 0;
  int nu = 0, nq = 0, ns = 0;
  logic [31:0] last_u = '0, last_q = '0;

  localparam logic [31:0] UVEC [4] = '{32'hDEADBEEF, 32'h00000001, 32'h80000000, 32'h5A3C96F0};
  localparam logic [5:0]  PAT = 6'b101101;

  always #2 clk = ~clk;

  cdsub_sync_rx uut (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .err_clr(err_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .user_word(user_word), .user_word_vld(user_word_vld),
    .q_word(q_word), .q_word_vld(q_word_vld),
    .frame_sync(frame_sync), .len_err(len_err));

  always @(posedge clk) if (rst_n) begin
    if (user_word_vld) begin nu++; last_u <= user_word; end
    if (q_word_vld)    begin nq++; last_q <= q_word;    end
    if (frame_sync)    ns++;
  end

  function automatic logic qf(int i);
    return ((i * 13) % 5) < 2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic clr);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; err_clr = clr;
  endtask

  task automatic send_data(input logic q, input logic clr);
    send_bit(1'b1, 1'b0);
    send_bit(q, 1'b0);
    for (int k = 5; k >= 1; k--) send_bit(PAT[k], 1'b0);
    send_bit(PAT[0], clr);
  endtask

  task automatic send_zero();
    for (int k = 0; k < 11; k++) send_bit(1'b0, 1'b0);
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0; err_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] expq;
    int s0, q0;
    repeat (3) @(negedge clk);
    // R2 R11: reset state
    check("R2 ready in reset", {31'b0, in_ready}, 32'd0);
    check("R11 outputs in reset", {28'b0, user_word_vld, q_word_vld, frame_sync, len_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 ready after reset", {31'b0, in_ready}, 32'd1);

    // R1: table walk, raw user words, subcode mode off
    for (int i = 0; i < 4; i++) begin
      for (int b = 31; b >= 0; b--) send_bit(UVEC[i][b], 1'b0);
      settle();
      check("R1 user word", last_u, UVEC[i]);
      check("R1 user word count", nu, i + 1);
    end

    // R9: sync pattern with mode off
    send_data(1'b1, 1'b0); send_zero(); send_zero(); send_data(1'b1, 1'b0);
    settle();
    check("R9 no sync when off", ns, 0);
    check("R9 no q when off", nq, 0);
    check("R9 no err when off", {31'b0, len_err}, 32'd0);

    // R4 R3: first sync with subcode mode on
    sync_en = 1'b1;
    send_data(1'b0, 1'b0); send_zero(); send_zero(); send_data(qf(0), 1'b0);
    settle();
    check("R4 first sync", ns, 1);
    check("R6 first sync no err", {31'b0, len_err}, 32'd0);

    // R4 R7 R8: a correct frame
    for (int i = 1; i < 96; i++) send_data(qf(i), 1'b0);
    send_zero(); send_zero(); send_data(qf(0), 1'b0);
    settle();
    for (int k = 0; k < 32; k++) expq[31-k] = qf(64 + k);
    check("R4 second sync", ns, 2);
    check("R8 q word count", nq, 3);
    check("R8 q word value", last_q, expq);
    check("R6 R7 good frame no err", {31'b0, len_err}, 32'd0);

    // R5 R6: flywheel on the 98th symbol without pattern
    for (int i = 1; i <= 98; i++) send_data(qf(i), 1'b0);
    settle();
    check("R5 flywheel sync", ns, 3);
    check("R6 flywheel err", {31'b0, len_err}, 32'd1);

    // R10: plain clear
    pulse_clear();
    check("R10 clear", {31'b0, len_err}, 32'd0);

    // R6 R10: early pattern with clear on the same edge
    for (int i = 0; i < 50; i++) send_data(1'b1, 1'b0);
    send_zero(); send_zero(); send_data(qf(0), 1'b1);
    settle();
    check("R4 early sync", ns, 4);
    check("R10 set wins over clear", {31'b0, len_err}, 32'd1);
    pulse_clear();
    check("R10 clear again", {31'b0, len_err}, 32'd0);

    // R7: right distance, wrong Q count (95 data symbols)
    for (int i = 0; i < 93; i++) send_data(1'b0, 1'b0);
    send_zero(); send_data(1'b0, 1'b0); send_zero(); send_zero(); send_data(qf(0), 1'b0);
    settle();
    check("R7 sync seen", ns, 5);
    check("R7 q count err", {31'b0, len_err}, 32'd1);
    pulse_clear();

    // R8 R6: a correct frame again, restart alignment verified
    q0 = nq; s0 = ns;
    for (int i = 1; i < 96; i++) send_data(qf(i), 1'b0);
    send_zero(); send_zero(); send_data(qf(0), 1'b0);
    settle();
    check("R8 q words after realign", nq - q0, 3);
    check("R8 q value after realign", last_q, expq);
    check("R6 good frame", {31'b0, len_err}, 32'd0);
    check("R4 sync after realign", ns - s0, 1);

    // R11: reset clears sticky flag
    for (int i = 1; i <= 98; i++) send_data(1'b1, 1'b0);
    settle();
    check("R6 err before reset", {31'b0, len_err}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R11 err after reset", {31'b0, len_err}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule